// File: doc/BRIEF.md
# Power-Good Assertion Delay

This block holds back the rising edge of an external power-good output until a programmed time has passed since an internal power-good condition became true. Software programs the delay as a 16-bit mantissa-exponent value in milliseconds. The block converts that value to a whole number of 200 µs ticks, rounding to the nearest tick, and stores the result. Counting uses a tick strobe from a local time base, not any shared system clock.

While the internal condition stays high, the block counts tick strobes. Once the programmed number of whole ticks has passed, the output goes high. It stays high for as long as the internal condition holds. If the internal condition falls at any time, the output falls in the same cycle and the count is discarded. The next rise of the internal condition starts a fresh, full delay.

Top module: `pg_assert_delay`

## Requirements
- R1: During reset and after reset `pgOut` is low, and the stored delay resets to zero ticks.
- R2: On a clock edge with `cfgWe` high, `cfgData` is stored as a delay of round(V × 5) ticks, rounding halves upward. V = Y × 2^N ms, where N is the two's-complement exponent in bits 15:11 and Y is the two's-complement mantissa in bits 10:0.
- R3: A mantissa of zero or less (bit 10 set, or bits 10:0 all zero) stores a delay of zero ticks.
- R4: A converted delay above 65500 ticks (13.1 s) is stored as 65500 ticks.
- R5: Counting starts at the clock edge that first samples `pgInt` high. From the next edge onward, an edge counts as a tick when it samples `tickStb` and `pgInt` both high. `pgOut` goes high right after the edge that samples the (D+1)-th tick, where D is the stored delay; a zero delay therefore asserts on the first tick.
- R6: Without tick strobes the count does not advance, so `pgOut` stays low even when the delay is zero.
- R7: When `pgInt` is low, `pgOut` is low in the same cycle. The count is discarded, and the next high `pgInt` starts the full delay again.
- R8: Once asserted, `pgOut` stays high for as long as `pgInt` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickStb | input | 1 | One-cycle strobe every 200 µs |
| pgInt | input | 1 | Internal power-good condition |
| cfgWe | input | 1 | Write strobe for the delay value |
| cfgData | input | 16 | Delay in mantissa-exponent milliseconds |
| pgOut | output | 1 | Delayed power-good output |

## Verification
The bench uses negative exponents to test rounding at 0.625 and 0.3125 ticks and at half-tick values. A design that truncates, or that shifts before multiplying, asserts one tick early on these values. Negative and zero mantissas are tested because a design that treats the mantissa as unsigned would load a huge delay. A request for 81840 ticks checks the clamp; a design that wraps instead of clamping would assert far too early. The bench also drops `pgInt` in the middle of a count and after assertion, to catch a count that resumes instead of restarting, and an output that lags the drop by one cycle.

// File: rtl/pgd_pkg.sv
package pgd_pkg;
  typedef enum logic [1:0] {
    PG_IDLE = 2'd0,
    PG_WAIT = 2'd1,
    PG_ON   = 2'd2
  } pgState_t;

  typedef struct packed {
    logic clear;
    logic advance;
  } ctlStrobe_t;
endpackage

// File: rtl/pgd_convert.sv
module pgd_convert #(
  parameter int TICKS_PER_MS = 5,
  parameter int MAX_TICKS    = 65500,
  localparam int TICK_W      = $clog2(MAX_TICKS + 1)
) (
  input  logic [15:0]       word,
  output logic [TICK_W-1:0] ticks
);
  localparam int WIDE = 40;

  logic signed [4:0]  expRaw;
  logic [4:0]         rShift;
  logic [WIDE-1:0]    scaled;
  logic [WIDE-1:0]    shifted;
  logic [WIDE-1:0]    halfLsb;
  logic               mantPositive;

  assign expRaw       = word[15:11];
  assign mantPositive = !word[10] && (word[9:0] != 10'd0);
  assign rShift       = ~expRaw + 5'd1;
  assign scaled       = WIDE'(word[9:0]) * WIDE'(TICKS_PER_MS);
  assign halfLsb      = (rShift == 5'd0) ? '0 : (WIDE'(1) << (rShift - 5'd1));

  always_comb begin
    if (!expRaw[4]) shifted = scaled << expRaw;
    else            shifted = (scaled + halfLsb) >> rShift;
    if (!mantPositive)                 ticks = '0;
    else if (shifted > WIDE'(MAX_TICKS)) ticks = TICK_W'(MAX_TICKS);
    else                               ticks = shifted[TICK_W-1:0];
  end
endmodule

// File: rtl/pgd_datapath.sv
module pgd_datapath
  import pgd_pkg::*;
#(
  parameter int TICKS_PER_MS = 5,
  parameter int MAX_TICKS    = 65500,
  localparam int TICK_W      = $clog2(MAX_TICKS + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [15:0] cfgData,
  input  ctlStrobe_t  strobe,
  output logic        delayDone
);
  logic [TICK_W-1:0] convTicks;
  logic [TICK_W-1:0] delayQ;
  logic [TICK_W-1:0] cntQ;

  pgd_convert #(.TICKS_PER_MS(TICKS_PER_MS), .MAX_TICKS(MAX_TICKS)) uConv (
    .word (cfgData),
    .ticks(convTicks)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      delayQ <= '0;
    else if (cfgWe) delayQ <= convTicks;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cntQ <= '0;
    else if (strobe.clear)   cntQ <= '0;
    else if (strobe.advance) cntQ <= cntQ + 1'b1;
  end

  assign delayDone = (cntQ >= delayQ);

  a_r4_clamp: assert property (@(posedge clk) disable iff (!rstN)
    delayQ <= TICK_W'(MAX_TICKS));

  a_r3_nonpositive_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && (cfgData[10] || cfgData[10:0] == 11'd0)) |=> (delayQ == '0));

  a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= TICK_W'(MAX_TICKS));
endmodule

// File: rtl/pgd_control.sv
module pgd_control
  import pgd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickStb,
  input  logic       pgInt,
  input  logic       delayDone,
  output ctlStrobe_t strobe,
  output logic       onQ
);
  pgState_t stateQ, stateNxt;

  always_comb begin
    stateNxt       = stateQ;
    strobe         = '0;
    case (stateQ)
      PG_IDLE: begin
        strobe.clear = 1'b1;
        if (pgInt) stateNxt = PG_WAIT;
      end
      PG_WAIT: begin
        if (!pgInt) stateNxt = PG_IDLE;
        else if (tickStb) begin
          if (delayDone) stateNxt = PG_ON;
          else           strobe.advance = 1'b1;
        end
      end
      PG_ON: begin
        if (!pgInt) stateNxt = PG_IDLE;
      end
      default: stateNxt = PG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= PG_IDLE;
    else       stateQ <= stateNxt;
  end

  assign onQ = (stateQ == PG_ON);

  a_r7_drop_restarts: assert property (@(posedge clk) disable iff (!rstN)
    !pgInt |=> (stateQ == PG_IDLE));

  a_r5_rise_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(onQ) |-> $past(tickStb));

  a_r6_wait_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PG_WAIT && pgInt && !tickStb) |=> (stateQ == PG_WAIT));

  a_r8_stay_on: assert property (@(posedge clk) disable iff (!rstN)
    (onQ && pgInt) |=> onQ);
endmodule

// File: rtl/pg_assert_delay.sv
module pg_assert_delay
  import pgd_pkg::*;
#(
  parameter int TICKS_PER_MS = 5,
  parameter int MAX_TICKS    = 65500
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickStb,
  input  logic        pgInt,
  input  logic        cfgWe,
  input  logic [15:0] cfgData,
  output logic        pgOut
);
  ctlStrobe_t strobe;
  logic       delayDone;
  logic       onQ;

  pgd_datapath #(.TICKS_PER_MS(TICKS_PER_MS), .MAX_TICKS(MAX_TICKS)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgData  (cfgData),
    .strobe   (strobe),
    .delayDone(delayDone)
  );

  pgd_control uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .tickStb  (tickStb),
    .pgInt    (pgInt),
    .delayDone(delayDone),
    .strobe   (strobe),
    .onQ      (onQ)
  );

  assign pgOut = onQ && pgInt;

  a_r1_low_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !pgOut);
endmodule

// File: tb/pg_assert_delay_test.sv
`timescale 1ns/1ps
module pg_assert_delay_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickStb = 1'b0;
  logic        pgInt = 1'b0;
  logic        cfgWe = 1'b0;
  logic [15:0] cfgData = 16'h0000;
  logic        pgOut;

  int checks = 0;
  int errors = 0;
  int tickPeriod = 3;
  int tickDiv = 0;
  bit done = 0;

  int mState = 0;
  int mCount = 0;
  int mDelay = 0;

  pg_assert_delay uut (
    .clk(clk), .rstN(rstN), .tickStb(tickStb), .pgInt(pgInt),
    .cfgWe(cfgWe), .cfgData(cfgData), .pgOut(pgOut)
  );

  always #2.5 clk = ~clk;

  function automatic int refTicks(logic [15:0] w);
    int n, y;
    real v;
    n = int'(w[15:11]);
    if (n > 15) n = n - 32;
    y = int'(w[10:0]);
    if (y > 1023) y = y - 2048;
    if (y <= 0) return 0;
    v = y * 5.0 * (2.0 ** n);
    v = $floor(v + 0.5);
    if (v > 65500.0) return 65500;
    return int'(v);
  endfunction

  always @(posedge clk) begin
    #1;
    if (tickPeriod == 0) tickStb = 1'b0;
    else begin
      tickDiv = (tickDiv + 1) % tickPeriod;
      tickStb = (tickDiv == 0);
    end
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mCount = 0; mDelay = 0;
    end else begin
      case (mState)
        0: begin mCount = 0; if (pgInt) mState = 1; end
        1: if (!pgInt) mState = 0;
           else if (tickStb) begin
             if (mCount >= mDelay) mState = 2; else mCount++;
           end
        default: if (!pgInt) mState = 0;
      endcase
      if (cfgWe) mDelay = refTicks(cfgData);
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (pgOut !== ((mState == 2) && pgInt)) begin
        errors++;
        $display("FAIL R5 model compare at %0t: pgOut=%b expected %b", $time, pgOut,
                 (mState == 2) && pgInt);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sync();
    @(posedge clk); #1;
  endtask

  task automatic measure(input bit doWrite, input logic [15:0] w, input int expT,
                         input string req);
    int cnt = 0;
    bit got = 0;
    sync(); pgInt = 1'b0;
    if (doWrite) begin cfgWe = 1'b1; cfgData = w; end
    sync(); cfgWe = 1'b0;
    sync(); pgInt = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 100000 && !got; i++) begin
      @(negedge clk);
      if (pgOut) got = 1;
      else if (tickStb) cnt++;
    end
    check(got && cnt == expT + 1, req, cnt, expT + 1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check(pgOut == 1'b0, "R1 in reset", pgOut, 0);
    rstN = 1'b1;
    sync();
    check(pgOut == 1'b0, "R1 after reset", pgOut, 0);
    measure(0, 16'h0000, 0, "R1 reset delay zero");
    measure(1, 16'h000A, 50, "R2 10ms");
    measure(1, 16'h1019, 500, "R2 100ms");
    measure(1, 16'hF801, 3, "R2 0.5ms half rounds up");
    measure(1, 16'hF003, 4, "R2 0.75ms");
    measure(1, 16'hE801, 1, "R2 0.625 ticks");
    measure(1, 16'hE001, 0, "R2 0.3125 ticks");
    measure(1, 16'h07FB, 0, "R3 negative mantissa");
    measure(1, 16'h7800, 0, "R3 zero mantissa");
    // R6: no strobes, zero delay, output must stay low
    tickPeriod = 0;
    sync(); pgInt = 1'b0; sync(); pgInt = 1'b1;
    repeat (50) sync();
    check(pgOut == 1'b0, "R6 no ticks", pgOut, 0);
    tickPeriod = 3;
    // R8 hold and R7 drop while on
    measure(1, 16'h0002, 10, "R2 2ms");
    repeat (40) sync();
    check(pgOut == 1'b1, "R8 held high", pgOut, 1);
    pgInt = 1'b0; #1;
    check(pgOut == 1'b0, "R7 same-cycle drop", pgOut, 0);
    // R7 drop mid-count then full restart
    sync(); pgInt = 1'b1;
    repeat (15) sync();
    check(pgOut == 1'b0, "R7 still counting", pgOut, 0);
    measure(0, 16'h0000, 10, "R7 full restart");
    // R4 saturation with a tick every cycle
    tickPeriod = 1;
    measure(1, 16'h23FF, 65500, "R4 clamp 81840");
    sync(); pgInt = 1'b0;
    sync();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #950000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule